// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer Counter

An 8-bit timer whose counting sequence is picked by a 3-bit mode code. It can run free, clear when it reaches a compare value, make a sawtooth for fast PWM, or make a triangle for phase-correct PWM. The count moves by one step for each cycle in which the `tick` input is high, so an external prescaler sets the rate. Two compare values, A and B, are written through a small register port. In some modes compare A also sets the turn-around value (TOP).

Each compare value has two copies: a buffer written by the port, and an active copy used by the comparators. Depending on the mode, the active copy follows the buffer at once or only at a defined point in the count cycle, so a new duty cycle never shortens the PWM period that is running. Combinational strobes report compare matches and the TOP and BOTTOM points when the counter steps. A sticky overflow flag is set at the mode's overflow point and stays set until software clears it.

Top module: `tmr8_wave`

## Requirements
- R1: After reset, `count`, `down` and `ovf_flag` are 0, both active compare values are 0, and no strobe is high while `tick` is low.
- R2: In mode 0 the count goes up by one on each tick and wraps from 255 to 0. The tick taken at count 255 sets `ovf_flag`.
- R3: In mode 2, TOP is active compare A. The tick taken at TOP loads 0 into the count. `ovf_flag` is set only by a tick taken at count 255.
- R4: In modes 3 and 7 the count rises to TOP and goes to 0 on the next tick. TOP is 255 in mode 3 and active compare A in mode 7. The overflow point is count 255 in mode 3 and TOP in mode 7.
- R5: In modes 1 (TOP 255) and 5 (TOP = active compare A) the count rises to TOP and then falls to 0, each end value lasting one tick. `down` is 1 while the count falls. The tick taken at 0 sets `ovf_flag`.
- R6: While `tick` is high in a valid mode: `match_a` is high when the count equals active A, `match_b` when it equals active B, `top_hit` when it equals TOP, and `bottom_hit` when it is 0.
- R7: A write with `wr_sel`=0 goes to buffer A, and one with `wr_sel`=1 goes to buffer B. In modes 0, 2, 4 and 6 the active copy takes the written value on the same edge. In modes 1, 3, 5 and 7 it is loaded only by the tick taken at TOP.
- R8: Modes 4 and 6 are reserved. Ticks leave the count unchanged, raise no strobe and do not set the flag.
- R9: `ovf_flag` stays set until a cycle with `ovf_clr` high. When a set and a clear fall in the same cycle, the flag ends up set.
- R10: In a cycle with `tick` low, the count and direction keep their values and every strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for one step |
| mode | input | 3 | Waveform mode code 0..7 |
| wr_en | input | 1 | Compare buffer write strobe |
| wr_sel | input | 1 | 0 selects compare A, 1 selects compare B |
| wr_data | input | 8 | Compare value to write |
| ovf_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current count |
| down | output | 1 | 1 while a phase-correct count falls |
| match_a | output | 1 | Compare A match strobe |
| match_b | output | 1 | Compare B match strobe |
| top_hit | output | 1 | Count at TOP on this tick |
| bottom_hit | output | 1 | Count at 0 on this tick |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest case to reach is the buffered compare in a PWM mode. A value written in the middle of a period must stay hidden for the rest of that period and take effect only after the tick at TOP. The bench first loads a known active value while in an immediate mode, then switches to fast PWM and writes a new value. It then looks at `match_a` at both the old and the new value, before the wrap and after it. Set-beats-clear is reached by running the count to 255 and asserting `tick` and `ovf_clr` in the same cycle.

// File: rtl/tmr8_wave.sv
module tmr8_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         down,
  output logic         match_a,
  output logic         match_b,
  output logic         top_hit,
  output logic         bottom_hit,
  output logic         ovf_flag
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] buf_a, buf_b, act_a, act_b, top;
  logic m_norm, m_ctc, m_fast8, m_fastA, m_phase, m_rsvd, top_is_a, imm;
  logic go, at_top, at_bot, ovf_set;

  assign m_norm   = (mode == 3'd0);
  assign m_ctc    = (mode == 3'd2);
  assign m_fast8  = (mode == 3'd3);
  assign m_fastA  = (mode == 3'd7);
  assign m_phase  = (mode == 3'd1) || (mode == 3'd5);
  assign m_rsvd   = (mode == 3'd4) || (mode == 3'd6);
  assign top_is_a = m_ctc || m_fastA || (mode == 3'd5);
  assign imm      = m_norm || m_ctc || m_rsvd;

  assign top    = top_is_a ? act_a : MAXV;
  assign go     = tick && !m_rsvd;
  assign at_top = (count == top);
  assign at_bot = (count == '0);

  assign match_a    = go && (count == act_a);
  assign match_b    = go && (count == act_b);
  assign top_hit    = go && at_top;
  assign bottom_hit = go && at_bot;

  assign ovf_set = go && (((m_norm || m_ctc || m_fast8) && count == MAXV) ||
                          (m_phase && at_bot) || (m_fastA && at_top));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_a <= '0;
      buf_b <= '0;
    end else if (wr_en) begin
      if (wr_sel) buf_b <= wr_data;
      else        buf_a <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
    end else if (imm) begin
      act_a <= (wr_en && !wr_sel) ? wr_data : buf_a;
      act_b <= (wr_en &&  wr_sel) ? wr_data : buf_b;
    end else if (go && at_top) begin
      act_a <= buf_a;
      act_b <= buf_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      down  <= 1'b0;
    end else if (go) begin
      if (m_phase) begin
        if (!down) begin
          if (at_top) begin
            if (top != '0) begin
              down  <= 1'b1;
              count <= count - ONE;
            end
          end else begin
            count <= count + ONE;
          end
        end else if (at_bot) begin
          down  <= 1'b0;
          count <= (top == '0) ? '0 : ONE;
        end else begin
          count <= count - ONE;
        end
      end else begin
        down  <= 1'b0;
        count <= (!m_norm && at_top) ? '0 : count + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_flag <= 1'b0;
    else        ovf_flag <= ovf_set || (ovf_flag && !ovf_clr);
  end

  a_r8_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && m_rsvd) |=> $stable(count));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(count) && $stable(down)));
  a_r10_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a || match_b || top_hit || bottom_hit) |-> tick);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> ovf_flag);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !ovf_set) |=> !ovf_flag);
  a_r5_turn_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (m_phase && tick && down && at_bot && top != '0) |=> (!down && count == ONE));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_fast8 || m_fastA || m_ctc) && tick && at_top) |=> (count == '0));
endmodule

// File: tb/tmr8_wave_bench.sv
`timescale 1ns/1ps
module tmr8_wave_bench;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, wr_sel = 0, ovf_clr = 0;
  logic [2:0] mode = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] count;
  logic down, match_a, match_b, top_hit, bottom_hit, ovf_flag;
  int checks = 0, errors = 0;
  logic [3:0] s;

  always #2 clk = ~clk;

  tmr8_wave u_tmr8_wave (.clk, .rst_n, .tick, .mode, .wr_en, .wr_sel, .wr_data,
    .ovf_clr, .count, .down, .match_a, .match_b, .top_hit, .bottom_hit, .ovf_flag);

  typedef struct packed {
    logic [2:0] m; logic [7:0] a; logic [15:0] n; logic [7:0] c; logic d;
  } vec_t;
  localparam vec_t VEC [9] = '{
    '{3'd0, 8'd0,  16'd5,   8'd5,   1'b0},  // R2
    '{3'd0, 8'd0,  16'd300, 8'd44,  1'b0},  // R2
    '{3'd2, 8'd10, 16'd25,  8'd3,   1'b0},  // R3
    '{3'd3, 8'd0,  16'd300, 8'd44,  1'b0},  // R4
    '{3'd7, 8'd20, 16'd50,  8'd8,   1'b0},  // R4
    '{3'd1, 8'd0,  16'd300, 8'd210, 1'b1},  // R5
    '{3'd5, 8'd10, 16'd13,  8'd7,   1'b1},  // R5
    '{3'd5, 8'd10, 16'd25,  8'd5,   1'b0},  // R5
    '{3'd4, 8'd10, 16'd7,   8'd0,   1'b0}   // R8
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; tick = 0; mode = 0; ovf_clr = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); mode = m;
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(posedge clk);
    #1 tick = 0;
  endtask

  task automatic pulse(output logic [3:0] st);
    @(negedge clk); tick = 1;
    #1 st = {match_a, match_b, top_hit, bottom_hit};
    @(posedge clk); #1 tick = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); ovf_clr = 1;
    @(posedge clk); #1 ovf_clr = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk("R1 count", count, 0);
    chk("R1 down", down, 0);
    chk("R1 flag", ovf_flag, 0);
    chk("R1 strobes", {match_a, match_b, top_hit, bottom_hit}, 0);

    foreach (VEC[i]) begin
      do_reset();
      wr(1'b0, VEC[i].a);
      wr(1'b1, 8'd0);
      set_mode(VEC[i].m);
      run(VEC[i].n);
      chk($sformatf("vector %0d count", i), count, VEC[i].c);
      chk($sformatf("vector %0d down", i), down, VEC[i].d);
    end

    // R2 overflow at MAX, R9 clear and set-wins
    do_reset();
    run(255);
    chk("R2 count at 255", count, 255);
    chk("R2 flag before MAX tick", ovf_flag, 0);
    run(1);
    chk("R2 flag after MAX tick", ovf_flag, 1);
    chk("R2 wrap", count, 0);
    run(3);
    chk("R9 sticky", ovf_flag, 1);
    clear_flag();
    chk("R9 cleared", ovf_flag, 0);
    run(252);
    @(negedge clk); tick = 1; ovf_clr = 1;
    @(posedge clk); #1 tick = 0; ovf_clr = 0;
    chk("R9 set wins over clear", ovf_flag, 1);

    // R3 CTC never reaches MAX
    do_reset();
    wr(1'b0, 8'd10);
    set_mode(3'd2);
    run(40);
    chk("R3 no overflow in CTC", ovf_flag, 0);

    // R4 mode 7 flag at TOP
    do_reset();
    wr(1'b0, 8'd20);
    set_mode(3'd7);
    run(20);
    chk("R4 flag before TOP tick", ovf_flag, 0);
    run(1);
    chk("R4 flag at TOP", ovf_flag, 1);
    chk("R4 wrap from TOP", count, 0);

    // R5 flag at BOTTOM
    do_reset();
    wr(1'b0, 8'd10);
    set_mode(3'd5);
    run(1);
    chk("R5 flag at first bottom", ovf_flag, 1);
    clear_flag();
    run(19);
    chk("R5 back at bottom", count, 0);
    chk("R5 falling", down, 1);
    chk("R5 flag not yet", ovf_flag, 0);
    run(1);
    chk("R5 flag at bottom", ovf_flag, 1);
    chk("R5 rising again", down, 0);

    // R6 strobes, R10 idle
    do_reset();
    wr(1'b0, 8'd5);
    wr(1'b1, 8'd7);
    pulse(s); chk("R6 bottom_hit", s, 4'b0001);
    run(4);
    pulse(s); chk("R6 match_a at 5", s, 4'b1000);
    pulse(s); chk("R6 none at 6", s, 4'b0000);
    pulse(s); chk("R6 match_b at 7", s, 4'b0100);
    repeat (10) @(negedge clk);
    chk("R10 count held", count, 8);
    chk("R10 strobes low", {match_a, match_b, top_hit, bottom_hit}, 0);
    run(247);
    pulse(s); chk("R6 top_hit at 255", s, 4'b0010);

    // R7 buffered compare in fast PWM
    do_reset();
    wr(1'b0, 8'd3);
    set_mode(3'd3);
    wr(1'b0, 8'd9);
    run(3);
    pulse(s); chk("R7 old value active", s[3], 1);
    run(5);
    pulse(s); chk("R7 new value hidden", s[3], 0);
    run(245);
    pulse(s);
    run(9);
    pulse(s); chk("R7 new value after TOP", s[3], 1);

    // R8 reserved mode holds
    do_reset();
    wr(1'b0, 8'd7);
    run(7);
    set_mode(3'd6);
    pulse(s); chk("R8 no strobes", s, 4'b0000);
    run(5);
    chk("R8 count held", count, 7);
    chk("R8 flag untouched", ovf_flag, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule